// File: doc/BRIEF.md
# Nested Software Priority Interrupt Controller

This block decides which interrupt a small CPU core takes next. It arbitrates a set of maskable interrupt vectors, 14 by default, together with three non-maskable sources: a system reset request, a top-level hardware interrupt line, and a software trap. Each maskable vector carries a 2-bit software priority, held in byte-wide priority registers on a simple register port. The CPU reports its current interrupt level as a 2-bit code. The controller compares the pending, enabled requests against that level and presents one winner: the vector index to service and the level code the CPU must load when it enters the handler.

Arbitration has two stages. The highest software priority wins first. Among vectors of equal software priority, the fixed hardware order decides, and the lower index wins. The non-maskable sources outrank every maskable vector, enter at the top level, and pay no attention to the current level. Maskable vectors are either edge-type or level-type, chosen per vector by a parameter. An edge-type request is latched until the CPU acknowledges that vector. A level-type request is seen only while its input is high. While the CPU is halted, only vectors marked as able to wake it may win. Any other pending vector waits until the halt input falls.

Top module: `nspic_top`

## Requirements
- R1: After reset every priority register reads FFh. Vector 4n+k has its 2-bit field at bits [2k+1:2k] of register address n.
- R2: Field positions beyond the last vector read as ones and ignore writes. With 14 vectors, bits 7:4 of address 3 always read 1.
- R3: A field written with the floor code 2'b10 keeps its previous value, while the other fields of the same write update. Example: CFh written with 64h becomes 44h. No grant ever carries level code 2'b10.
- R4: Level codes rank, from lowest to highest, 2'b10, 2'b01, 2'b00, 2'b11. A maskable vector can win only when its enable is 1 and its field ranks strictly above cur_lvl_i.
- R5: Among eligible maskable vectors, the highest-ranked field wins. On equal rank, the lowest vector index wins.
- R6: Grants are registered. irq_o=1 presents vec_o, with maskable vectors coded by their index, and lvl_o equal to the winner's priority field.
- R7: Non-maskable sources win over all maskable vectors in this order: reset request (vec_o=NUM_VEC+2), then the top-level line (NUM_VEC+1), then the trap (NUM_VEC). They ignore cur_lvl_i and the halt input, and they grant lvl_o=2'b11. The reset request acts while its input is high.
- R8: While halt_i=1, a maskable vector can win only if its wake_mask_i bit is 1. Other vectors stay pending and win after halt_i falls.
- R9: An edge-type vector latches a rising edge of its request input. It remains pending until ack_i is high while that vector is granted. In that same cycle it is excluded from the grant that gets registered.
- R10: A level-type vector is pending exactly while its request input is high. An acknowledge excludes it from the grant for one cycle only and does not clear it.
- R11: A pending edge-type request that is disabled, or that ranks too low, stays latched. It wins once it becomes eligible.
- R12: The top-level line and the trap latch on rising edges of their inputs, and an acknowledge of the granted one clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_VEC | Maskable request inputs |
| en_i | input | NUM_VEC | Per-vector enables |
| wake_mask_i | input | NUM_VEC | 1 marks a vector able to end halt |
| halt_i | input | 1 | CPU is halted |
| cur_lvl_i | input | 2 | Current CPU interrupt level code |
| tli_i | input | 1 | Top-level hardware interrupt line |
| trap_i | input | 1 | Software trap pulse |
| rst_req_i | input | 1 | Reset request |
| ack_i | input | 1 | CPU takes the presented grant |
| reg_we_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | ADDR_W | Priority register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | A grant is presented |
| vec_o | output | VEC_W | Granted vector code |
| lvl_o | output | 2 | Level code to load on entry |

## Verification
The bench builds the block with its defaults: 14 vectors, vectors 0 to 7 edge-type and 8 to 13 level-type. With this setting the last priority register holds two live fields and two read-only ones, and both latching behaviours sit side by side. Level-type vectors make the table-driven part stateless, covering ties, strict-rank masking, enables and halt filtering. Edge-type vectors carry the directed runs on acknowledge, nesting, deferred service and wake from halt.

// File: rtl/nspic_pkg.sv
package nspic_pkg;

    // Lowest level code: refused by the priority registers
    localparam logic [1:0] LVL_FLOOR = 2'b10;
    // Highest level code: used by non-maskable entries
    localparam logic [1:0] LVL_TOP   = 2'b11;

    // Map a level code onto a monotonic rank: 10->0, 01->1, 00->2, 11->3
    function automatic logic [1:0] lvl_rank(input logic [1:0] code);
        return {code[1] ~^ code[0], code[0]};
    endfunction

endpackage

// File: rtl/nspic_prio_file.sv
module nspic_prio_file #(
    parameter int unsigned NUM_VEC = 14,
    parameter int unsigned ADDR_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [7:0]             wdata_i,
    output logic [7:0]             rdata_o,
    output logic [2*NUM_VEC-1:0]   prio_o
);
    import nspic_pkg::*;

    localparam int unsigned FLD_PER_REG = 4;

    typedef struct packed {
        logic [2*NUM_VEC-1:0] fld;
    } pf_state_t;

    pf_state_t   st_d, st_q;
    int unsigned widx, ridx;

    // Next state: fields of the addressed register, floor code refused
    always_comb begin
        st_d = st_q;
        widx = 0;
        if (we_i) begin
            for (int k = 0; k < FLD_PER_REG; k++) begin
                widx = int'(addr_i) * FLD_PER_REG + k;
                if (widx < NUM_VEC && wdata_i[2*k +: 2] != LVL_FLOOR) begin
                    st_d.fld[2*widx +: 2] = wdata_i[2*k +: 2];
                end
            end
        end
    end

    // Read path: absent fields read as ones
    always_comb begin
        rdata_o = 8'hFF;
        ridx    = 0;
        for (int k = 0; k < FLD_PER_REG; k++) begin
            ridx = int'(addr_i) * FLD_PER_REG + k;
            if (ridx < NUM_VEC) begin
                rdata_o[2*k +: 2] = st_q.fld[2*ridx +: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign prio_o = st_q.fld;

endmodule

// File: rtl/nspic_pend.sv
module nspic_pend #(
    parameter int unsigned NUM_VEC   = 14,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req_i,
    input  logic               tli_i,
    input  logic               trap_i,
    input  logic [NUM_VEC-1:0] clr_i,
    input  logic               tli_clr_i,
    input  logic               trap_clr_i,
    output logic [NUM_VEC-1:0] pend_o,
    output logic               tli_pend_o,
    output logic               trap_pend_o
);
    localparam logic [NUM_VEC-1:0] EDGE_VEC = EDGE_MASK[NUM_VEC-1:0];

    typedef struct packed {
        logic [NUM_VEC-1:0] req_prev;
        logic [NUM_VEC-1:0] latch;
        logic               tli_prev;
        logic               tli_lat;
        logic               trap_prev;
        logic               trap_lat;
    } pd_state_t;

    pd_state_t st_d, st_q;

    // A new edge in the clearing cycle survives (set wins)
    always_comb begin
        st_d           = st_q;
        st_d.req_prev  = req_i;
        st_d.latch     = ((st_q.latch & ~clr_i) | (req_i & ~st_q.req_prev)) & EDGE_VEC;
        st_d.tli_prev  = tli_i;
        st_d.tli_lat   = (st_q.tli_lat & ~tli_clr_i) | (tli_i & ~st_q.tli_prev);
        st_d.trap_prev = trap_i;
        st_d.trap_lat  = (st_q.trap_lat & ~trap_clr_i) | (trap_i & ~st_q.trap_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        if (EDGE_MASK[i]) begin : g_edge
            assign pend_o[i] = st_q.latch[i];
        end else begin : g_level
            assign pend_o[i] = req_i[i];
        end
    end

    assign tli_pend_o  = st_q.tli_lat;
    assign trap_pend_o = st_q.trap_lat;

endmodule

// File: rtl/nspic_arb.sv
module nspic_arb #(
    parameter int unsigned NUM_VEC = 14,
    parameter int unsigned VEC_W   = 5
) (
    input  logic [NUM_VEC-1:0]   pend_i,
    input  logic [NUM_VEC-1:0]   en_i,
    input  logic [NUM_VEC-1:0]   wake_mask_i,
    input  logic                 halt_i,
    input  logic [1:0]           cur_lvl_i,
    input  logic [2*NUM_VEC-1:0] prio_i,
    input  logic                 tli_i,
    input  logic                 trap_i,
    input  logic                 rst_req_i,
    output logic                 valid_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic [1:0]           lvl_o
);
    import nspic_pkg::*;

    localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(NUM_VEC);
    localparam logic [VEC_W-1:0] V_TLI  = VEC_W'(NUM_VEC + 1);
    localparam logic [VEC_W-1:0] V_RST  = VEC_W'(NUM_VEC + 2);

    logic [1:0]         fld_code [NUM_VEC];
    logic [1:0]         fld_rank [NUM_VEC];
    logic [NUM_VEC-1:0] elig;
    logic [1:0]         cur_rank;

    logic               found;
    logic [1:0]         best_rank;
    logic [1:0]         best_code;
    logic [VEC_W-1:0]   best_idx;

    assign cur_rank = lvl_rank(cur_lvl_i);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_elig
        assign fld_code[i] = prio_i[2*i +: 2];
        assign fld_rank[i] = lvl_rank(fld_code[i]);
        assign elig[i]     = pend_i[i] && en_i[i]
                             && (!halt_i || wake_mask_i[i])
                             && (fld_rank[i] > cur_rank);
    end

    // Walk from the highest index down; ">=" lets a lower index take ties
    always_comb begin
        found     = 1'b0;
        best_rank = '0;
        best_code = '0;
        best_idx  = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (elig[i] && (!found || fld_rank[i] >= best_rank)) begin
                found     = 1'b1;
                best_rank = fld_rank[i];
                best_code = fld_code[i];
                best_idx  = VEC_W'(i);
            end
        end
    end

    always_comb begin
        valid_o = 1'b1;
        vec_o   = '0;
        lvl_o   = LVL_TOP;
        if (rst_req_i) begin
            vec_o = V_RST;
        end else if (tli_i) begin
            vec_o = V_TLI;
        end else if (trap_i) begin
            vec_o = V_TRAP;
        end else if (found) begin
            vec_o = best_idx;
            lvl_o = best_code;
        end else begin
            valid_o = 1'b0;
            lvl_o   = '0;
        end
    end

endmodule

// File: rtl/nspic_top.sv
module nspic_top #(
    parameter int unsigned NUM_VEC   = 14,
    parameter logic [31:0] EDGE_MASK = 32'h0000_00FF,
    localparam int unsigned NUM_REGS = (NUM_VEC + 3) / 4,
    localparam int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned VEC_W    = $clog2(NUM_VEC + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req_i,
    input  logic [NUM_VEC-1:0] en_i,
    input  logic [NUM_VEC-1:0] wake_mask_i,
    input  logic               halt_i,
    input  logic [1:0]         cur_lvl_i,
    input  logic               tli_i,
    input  logic               trap_i,
    input  logic               rst_req_i,
    input  logic               ack_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [1:0]         lvl_o
);
    localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(NUM_VEC);
    localparam logic [VEC_W-1:0] V_TLI  = VEC_W'(NUM_VEC + 1);

    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
        logic [1:0]       lvl;
    } gr_state_t;

    gr_state_t st_d, st_q;

    logic                 ack_take;
    logic [NUM_VEC-1:0]   clr_mask;
    logic                 tli_clr, trap_clr;
    logic [NUM_VEC-1:0]   pend_raw;
    logic                 tli_raw, trap_raw;
    logic [2*NUM_VEC-1:0] prio;
    logic                 sel_valid;
    logic [VEC_W-1:0]     sel_vec;
    logic [1:0]           sel_lvl;

    // Acknowledge applies to the grant currently presented
    assign ack_take = ack_i && st_q.irq;
    assign tli_clr  = ack_take && (st_q.vec == V_TLI);
    assign trap_clr = ack_take && (st_q.vec == V_TRAP);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_clr
        assign clr_mask[i] = ack_take && (st_q.vec == VEC_W'(i));
    end

    nspic_prio_file #(
        .NUM_VEC (NUM_VEC),
        .ADDR_W  (ADDR_W)
    ) prio_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .prio_o  (prio)
    );

    nspic_pend #(
        .NUM_VEC   (NUM_VEC),
        .EDGE_MASK (EDGE_MASK)
    ) pend_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .tli_i       (tli_i),
        .trap_i      (trap_i),
        .clr_i       (clr_mask),
        .tli_clr_i   (tli_clr),
        .trap_clr_i  (trap_clr),
        .pend_o      (pend_raw),
        .tli_pend_o  (tli_raw),
        .trap_pend_o (trap_raw)
    );

    // The acknowledged source is kept out of the grant registered with it
    nspic_arb #(
        .NUM_VEC (NUM_VEC),
        .VEC_W   (VEC_W)
    ) arb_i (
        .pend_i      (pend_raw & ~clr_mask),
        .en_i        (en_i),
        .wake_mask_i (wake_mask_i),
        .halt_i      (halt_i),
        .cur_lvl_i   (cur_lvl_i),
        .prio_i      (prio),
        .tli_i       (tli_raw && !tli_clr),
        .trap_i      (trap_raw && !trap_clr),
        .rst_req_i   (rst_req_i),
        .valid_o     (sel_valid),
        .vec_o       (sel_vec),
        .lvl_o       (sel_lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = sel_valid;
        st_d.vec = sel_vec;
        st_d.lvl = sel_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign vec_o = st_q.vec;
    assign lvl_o = st_q.lvl;

endmodule

// File: rtl/nspic_chk.sv
module nspic_chk #(
    parameter int unsigned NUM_VEC = 14,
    parameter int unsigned VEC_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_VEC-1:0] en_i,
    input logic [NUM_VEC-1:0] wake_mask_i,
    input logic               halt_i,
    input logic [1:0]         cur_lvl_i,
    input logic               rst_req_i,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [1:0]         lvl_o
);
    import nspic_pkg::*;

    localparam logic [VEC_W-1:0] FIRST_NM = VEC_W'(NUM_VEC);
    localparam logic [VEC_W-1:0] V_RST    = VEC_W'(NUM_VEC + 2);

    // Inputs as seen at the edge that registered the current grant
    logic [NUM_VEC-1:0] en_q, wake_q;
    logic               halt_q;
    logic [1:0]         cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            wake_q <= '0;
            halt_q <= 1'b0;
            cur_q  <= LVL_TOP;
        end else begin
            en_q   <= en_i;
            wake_q <= wake_mask_i;
            halt_q <= halt_i;
            cur_q  <= cur_lvl_i;
        end
    end

    logic maskable, en_hit, wake_hit;
    assign maskable = irq_o && (vec_o < FIRST_NM);
    assign en_hit   = |(en_q   & (NUM_VEC'(1) << vec_o));
    assign wake_hit = |(wake_q & (NUM_VEC'(1) << vec_o));

    assert_floor_never_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> lvl_o != LVL_FLOOR);

    assert_rank_above_current_R4: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> lvl_rank(lvl_o) > lvl_rank(cur_q));

    assert_grant_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        maskable |-> en_hit);

    assert_nonmaskable_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !maskable) |-> lvl_o == LVL_TOP);

    assert_reset_request_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_i |=> (irq_o && vec_o == V_RST));

    assert_halt_wake_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (maskable && halt_q) |-> wake_hit);

endmodule

bind nspic_top nspic_chk #(
    .NUM_VEC (NUM_VEC),
    .VEC_W   (VEC_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .wake_mask_i (wake_mask_i),
    .halt_i      (halt_i),
    .cur_lvl_i   (cur_lvl_i),
    .rst_req_i   (rst_req_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .lvl_o       (lvl_o)
);

// File: tb/nspic_top_tb_top.sv
`timescale 1ns/1ps
module nspic_top_tb_top;

    localparam int NV = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] req = '0, en = '0, wake = '0;
    logic          halt = 1'b0, tli = 1'b0, trap = 1'b0, rst_req = 1'b0, ack = 1'b0;
    logic [1:0]    cur = 2'b11;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq;
    logic [4:0]    vec;
    logic [1:0]    lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nspic_top dut_i (
        .clk (clk), .rst_n (rst_n), .req_i (req), .en_i (en), .wake_mask_i (wake),
        .halt_i (halt), .cur_lvl_i (cur), .tli_i (tli), .trap_i (trap),
        .rst_req_i (rst_req), .ack_i (ack), .reg_we_i (we), .reg_addr_i (addr),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq), .vec_o (vec),
        .lvl_o (lvl)
    );

    typedef struct packed {
        logic [NV-1:0] req;
        logic [NV-1:0] en;
        logic [1:0]    cur;
        logic          halt;
        logic [NV-1:0] wake;
        logic          eirq;
        logic [4:0]    evec;
        logic [1:0]    elvl;
        logic [3:0]    rq;
    } row_t;

    // Level-type vectors only (8..13); fields: 8=00 9=11 10=11 11=00 12=00 13=00
    localparam row_t TBL [13] = '{
        '{14'h0100, 14'h3FFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd8,  2'b00, 4'd4}, // R4 single
        '{14'h0300, 14'h3FFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd9,  2'b11, 4'd5}, // R5 rank wins
        '{14'h0600, 14'h3FFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd9,  2'b11, 4'd5}, // R5 tie low idx
        '{14'h1900, 14'h3FFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd8,  2'b00, 4'd5}, // R5 three-way tie
        '{14'h0100, 14'h3FFF, 2'b00, 1'b0, 14'h0000, 1'b0, 5'd0,  2'b00, 4'd4}, // R4 equal rank blocked
        '{14'h0300, 14'h3FFF, 2'b00, 1'b0, 14'h0000, 1'b1, 5'd9,  2'b11, 4'd4}, // R4 strictly above
        '{14'h0200, 14'h3FFF, 2'b11, 1'b0, 14'h0000, 1'b0, 5'd0,  2'b00, 4'd4}, // R4 top level blocks
        '{14'h0300, 14'h3DFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd8,  2'b00, 4'd4}, // R4 disabled skipped
        '{14'h3F00, 14'h0000, 2'b10, 1'b0, 14'h0000, 1'b0, 5'd0,  2'b00, 4'd4}, // R4 none enabled
        '{14'h2800, 14'h3FFF, 2'b01, 1'b0, 14'h0000, 1'b1, 5'd11, 2'b00, 4'd4}, // R4 code order
        '{14'h1200, 14'h3FFF, 2'b10, 1'b1, 14'h1000, 1'b1, 5'd12, 2'b00, 4'd8}, // R8 wake only
        '{14'h1200, 14'h3FFF, 2'b10, 1'b1, 14'h0000, 1'b0, 5'd0,  2'b00, 4'd8}, // R8 none can wake
        '{14'h1200, 14'h3FFF, 2'b10, 1'b0, 14'h0000, 1'b1, 5'd9,  2'b11, 4'd8}  // R8 after halt
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_grant(input logic eirq, input logic [4:0] evec,
                               input logic [1:0] elvl, input string tag);
        checks++;
        if (irq !== eirq || (eirq && (vec !== evec || lvl !== elvl))) begin
            fails++;
            $display("FAIL %s: irq=%0b vec=%0d lvl=%b expected irq=%0b vec=%0d lvl=%b",
                     tag, irq, vec, lvl, eirq, evec, elvl);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick(1);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg %0d read %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic pulse_req(input logic [NV-1:0] m);
        req = req | m;
        tick(1);
        req = req & ~m;
    endtask

    task automatic ack_pulse(input logic [1:0] new_cur);
        ack = 1'b1; cur = new_cur;
        tick(1);
        ack = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check_grant(1'b0, 5'd0, 2'b00, "R1 no grant after reset");
        for (int a = 0; a < 4; a++) rd(a[1:0], 8'hFF, "R1 reset value");

        // R3 floor code refused per field
        wr(2'd0, 8'hCF); rd(2'd0, 8'hCF, "R3 plain write");
        wr(2'd0, 8'h64); rd(2'd0, 8'h44, "R3 floor field kept");
        wr(2'd1, 8'hD4); rd(2'd1, 8'hD4, "R1 register 1");
        wr(2'd2, 8'h3C); rd(2'd2, 8'h3C, "R1 register 2");
        wr(2'd2, 8'hBE); rd(2'd2, 8'h3C, "R3 two floor fields");
        // R2 read-only upper bits of the last register
        wr(2'd3, 8'h00); rd(2'd3, 8'hF0, "R2 upper bits ones");

        // Table walk
        for (int i = 0; i < 13; i++) begin
            req = TBL[i].req; en = TBL[i].en; cur = TBL[i].cur;
            halt = TBL[i].halt; wake = TBL[i].wake;
            tick(2);
            check_grant(TBL[i].eirq, TBL[i].evec, TBL[i].elvl,
                        $sformatf("R%0d table row %0d", TBL[i].rq, i));
        end
        req = '0; en = '1; cur = 2'b10; halt = 1'b0; wake = '0;
        tick(2);

        // R1 field position: vector 7 at bits 7:6 of register 1 (code 11)
        cur = 2'b00;
        pulse_req(14'h0080); tick(2);
        check_grant(1'b1, 5'd7, 2'b11, "R1 vector 7 field");
        ack_pulse(2'b11);
        check_grant(1'b0, 5'd0, 2'b00, "R9 cleared on ack");
        cur = 2'b10;

        // R9 edge latch and acknowledge
        pulse_req(14'h0002); tick(2);
        check_grant(1'b1, 5'd1, 2'b01, "R9 edge latched");
        ack_pulse(2'b01);
        check_grant(1'b0, 5'd0, 2'b00, "R9 excluded at ack");
        cur = 2'b10; tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R9 stays cleared");

        // R11 disabled request stays latched
        en[2] = 1'b0;
        pulse_req(14'h0004); tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R11 disabled held");
        en[2] = 1'b1; tick(2);
        check_grant(1'b1, 5'd2, 2'b00, "R11 served when enabled");
        ack_pulse(2'b00); cur = 2'b10; tick(2);

        // R5 nesting: higher rank first, lower one after return
        pulse_req(14'h0018); tick(2);
        check_grant(1'b1, 5'd4, 2'b00, "R5 higher rank first");
        ack_pulse(2'b00);
        check_grant(1'b0, 5'd0, 2'b00, "R4 lower rank held in handler");
        cur = 2'b10; tick(2);
        check_grant(1'b1, 5'd3, 2'b01, "R11 deferred vector served");
        ack_pulse(2'b01); cur = 2'b10; tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R9 all cleared");

        // R10 level-type vector
        req[8] = 1'b1; tick(2);
        check_grant(1'b1, 5'd8, 2'b00, "R10 level grant");
        ack_pulse(2'b10);
        check_grant(1'b0, 5'd0, 2'b00, "R10 excluded in ack cycle");
        tick(1);
        check_grant(1'b1, 5'd8, 2'b00, "R10 ack does not clear");
        req[8] = 1'b0; tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R10 follows input");

        // R7 and R12 non-maskable sources
        req[9] = 1'b1; tick(2);
        check_grant(1'b1, 5'd9, 2'b11, "R6 maskable baseline");
        trap = 1'b1; tick(1); trap = 1'b0; tick(2);
        check_grant(1'b1, 5'd14, 2'b11, "R12 trap latched");
        cur = 2'b11;
        tli = 1'b1; tick(1); tli = 1'b0; tick(2);
        check_grant(1'b1, 5'd15, 2'b11, "R7 line over trap");
        rst_req = 1'b1; tick(2);
        check_grant(1'b1, 5'd16, 2'b11, "R7 reset request wins");
        rst_req = 1'b0; tick(2);
        check_grant(1'b1, 5'd15, 2'b11, "R7 line after reset request");
        ack_pulse(2'b11);
        check_grant(1'b1, 5'd14, 2'b11, "R12 line cleared by ack");
        ack_pulse(2'b11);
        check_grant(1'b0, 5'd0, 2'b00, "R12 trap cleared by ack");
        cur = 2'b10; tick(2);
        check_grant(1'b1, 5'd9, 2'b11, "R4 maskable resumes");
        req[9] = 1'b0; tick(2);

        // R8 wake from halt with edge-type vectors
        halt = 1'b1; wake = 14'h0001;
        pulse_req(14'h0020); tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R8 non-wake held in halt");
        pulse_req(14'h0001); tick(2);
        check_grant(1'b1, 5'd0, 2'b00, "R8 wake vector first");
        ack_pulse(2'b00);
        check_grant(1'b0, 5'd0, 2'b00, "R8 still held");
        halt = 1'b0; cur = 2'b10; tick(2);
        check_grant(1'b1, 5'd5, 2'b01, "R8 served after halt");
        ack_pulse(2'b01); cur = 2'b10; tick(2);
        check_grant(1'b0, 5'd0, 2'b00, "R9 idle at end");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule